// File: doc/BRIEF.md
# Sample Output Demultiplexer and Formatter

This block sits behind the binary encoder of an 8-bit sampling converter. It takes one conversion code on every sample clock edge and presents the results on two output ports, A and B. It also drives a strobe whose rising edge tells downstream capture logic that the ports hold valid data. A mode input chooses between two layouts. In straight layout both ports update on every clock, and B trails A by one sample. In paired layout an internal divide-by-two phase steers alternate samples to A and B, so each port runs at half the sample rate.

The active-low synchronous reset puts the divider into a known phase and clears the pipeline. Several instances that share a sample clock and a reset pulse therefore emit identical port words and strobes, cycle for cycle. A polarity input selects plain binary or the bitwise complement of every output code. The mode is captured only while reset is held.

Top module: `sample_demux_fmt`

## Requirements
- R1: `paired_mode` is captured only on clock edges where `rst_n` is low. 0 selects straight layout and 1 selects paired layout. A change of `paired_mode` while `rst_n` is high has no effect until the next reset.
- R2: In straight layout, a code applied before the k-th clock edge after reset release (k = 0 first) appears on `port_a` after edge k+LAT-1.
- R3: In straight layout, whenever `port_a` takes a new sample, `port_b` takes the sample that `port_a` held before, so B is always one sample older than A. Before any sample arrives, B reads 0.
- R4: In straight layout, `strobe` is the inverse of `clk`: high while the clock is low and low while it is high.
- R5: In paired layout, even-numbered samples after reset (0, 2, ...) go to `port_a` and odd-numbered samples go to `port_b`. A port is written on alternate edges, and the other port keeps its value.
- R6: In paired layout, `strobe` rises on the edge that writes `port_b` and falls on the edge that writes `port_a`. Its rising edge marks a complete A/B pair (A = sample 2m, B = sample 2m+1), and it is never high for two consecutive cycles.
- R7: With `pol_true` = 1, codes pass unchanged (0xFF top, 0x80 mid, 0x00 bottom). With `pol_true` = 0, every bit is inverted (0xFF->0x00, 0x80->0x7F, 0x00->0xFF). Polarity is applied at the edge where the sample is captured.
- R8: While `rst_n` is low, both ports read 0x00 and, in paired layout, `strobe` is low. The divider restarts so that the first sample after release goes to `port_a`.
- R9: Two instances that share `clk` and input data and that leave reset on the same edge give identical `port_a`, `port_b` and `strobe` on every cycle. Instances released on different edges can differ in strobe phase.
- R10: The latency from capture to the port that holds a sample is LAT clocks (default 2) in both layouts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous active-low reset; aligns the divider and latches the mode |
| sample_in | input | CODE_W | Conversion code, one per clock |
| paired_mode | input | 1 | 1 = paired (1:2) layout, 0 = straight layout, latched in reset |
| pol_true | input | 1 | 1 = plain binary, 0 = complemented output codes |
| port_a | output | CODE_W | Output port A |
| port_b | output | CODE_W | Output port B |
| strobe | output | 1 | Data-valid strobe; inverted clock in straight layout, half-rate in paired layout |

## Verification
A divider phase that is wrong after reset shows up at once. The first post-reset sample lands on B instead of A, and the strobe is high on the cycle where it should be low, within LAT clocks of release. A pipeline register that is missing or doubled moves every ramp value on A by one cycle, so the first data check fails. A latched mode that follows the live input turns the strobe from an inverted clock into a half-rate pulse on the cycle after the input changes. Two instances whose dividers disagree show strobes of opposite phase on every cycle.

// File: rtl/sample_demux_fmt_pkg.sv
// Shared types for the sample output formatter.
// Assumes: one layout select bit and one steering bit.
package sample_demux_fmt_pkg;
    typedef enum logic {
        LAYOUT_STRAIGHT = 1'b0,
        LAYOUT_PAIRED   = 1'b1
    } layout_e;

    typedef enum logic {
        DEST_A = 1'b0,
        DEST_B = 1'b1
    } dest_e;
endpackage

// File: rtl/sfmt_half_div.sv
// Half-rate steering divider with mode latch.
// Does: latches the layout during reset and toggles the destination each
// clock in paired layout. Assumes: reset is synchronous, active low.
module sfmt_half_div
    import sample_demux_fmt_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    paired_mode,
    output layout_e layout_q,
    output dest_e   dest_q
);
    // Latch the layout in reset; alternate the destination in paired layout.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            layout_q <= paired_mode ? LAYOUT_PAIRED : LAYOUT_STRAIGHT;
            dest_q   <= DEST_A;
        end else if (layout_q == LAYOUT_PAIRED) begin
            dest_q   <= (dest_q == DEST_A) ? DEST_B : DEST_A;
        end
    end
endmodule

// File: rtl/sfmt_pipe.sv
// Capture-and-delay pipeline of LAT-1 stages.
// Does: captures the code with polarity applied and tags it with its
// destination. Assumes: LAT >= 2; the final register is the port stage.
module sfmt_pipe
    import sample_demux_fmt_pkg::*;
#(
    parameter int CODE_W = 8,
    parameter int LAT    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] sample_in,
    input  logic              pol_true,
    input  dest_e             dest_in,
    output logic [CODE_W-1:0] code_out,
    output dest_e             dest_out,
    output logic              vld_out
);
    localparam int STAGES = LAT - 1;

    logic [CODE_W-1:0] code_r [STAGES];
    dest_e             dest_r [STAGES];
    logic              vld_r  [STAGES];

    // Capture stage: apply polarity, record destination, mark valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_r[0] <= '0;
            dest_r[0] <= DEST_A;
            vld_r[0]  <= 1'b0;
        end else begin
            code_r[0] <= pol_true ? sample_in : ~sample_in;
            dest_r[0] <= dest_in;
            vld_r[0]  <= 1'b1;
        end
    end

    // Extra delay stages when LAT exceeds two.
    for (genvar s = 1; s < STAGES; s++) begin : g_dly
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                code_r[s] <= '0;
                dest_r[s] <= DEST_A;
                vld_r[s]  <= 1'b0;
            end else begin
                code_r[s] <= code_r[s-1];
                dest_r[s] <= dest_r[s-1];
                vld_r[s]  <= vld_r[s-1];
            end
        end
    end

    assign code_out = code_r[STAGES-1];
    assign dest_out = dest_r[STAGES-1];
    assign vld_out  = vld_r[STAGES-1];
endmodule

// File: rtl/sfmt_ports.sv
// Output port registers and paired-layout strobe register.
// Does: straight layout shifts A into B; paired layout writes the tagged
// port and raises the strobe after a B write. Assumes: vld stays high once set.
module sfmt_ports
    import sample_demux_fmt_pkg::*;
#(
    parameter int CODE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  layout_e           layout_q,
    input  logic [CODE_W-1:0] code_in,
    input  dest_e             dest_in,
    input  logic              vld_in,
    output logic [CODE_W-1:0] port_a,
    output logic [CODE_W-1:0] port_b,
    output logic              pair_stb
);
    // Write the ports according to layout and destination tag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            port_a   <= '0;
            port_b   <= '0;
            pair_stb <= 1'b0;
        end else if (vld_in) begin
            if (layout_q == LAYOUT_STRAIGHT) begin
                port_a   <= code_in;
                port_b   <= port_a;
                pair_stb <= 1'b0;
            end else if (dest_in == DEST_A) begin
                port_a   <= code_in;
                pair_stb <= 1'b0;
            end else begin
                port_b   <= code_in;
                pair_stb <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/sample_demux_fmt.sv
// Top: formats converter codes onto two ports with a capture strobe.
// Does: straight or paired layout, polarity select, reset-aligned divider.
// Assumes: a single sample clock; reset is synchronous, active low.
module sample_demux_fmt
    import sample_demux_fmt_pkg::*;
#(
    parameter int CODE_W = 8,
    parameter int LAT    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] sample_in,
    input  logic              paired_mode,
    input  logic              pol_true,
    output logic [CODE_W-1:0] port_a,
    output logic [CODE_W-1:0] port_b,
    output logic              strobe
);
    layout_e           layout_q;
    dest_e             dest_q;
    dest_e             pipe_dest;
    logic [CODE_W-1:0] pipe_code;
    logic              pipe_vld;
    logic              pair_stb;
    logic              paired;

    sfmt_half_div u_div (
        .clk         (clk),
        .rst_n       (rst_n),
        .paired_mode (paired_mode),
        .layout_q    (layout_q),
        .dest_q      (dest_q)
    );

    sfmt_pipe #(.CODE_W(CODE_W), .LAT(LAT)) u_pipe (
        .clk       (clk),
        .rst_n     (rst_n),
        .sample_in (sample_in),
        .pol_true  (pol_true),
        .dest_in   (dest_q),
        .code_out  (pipe_code),
        .dest_out  (pipe_dest),
        .vld_out   (pipe_vld)
    );

    sfmt_ports #(.CODE_W(CODE_W)) u_ports (
        .clk      (clk),
        .rst_n    (rst_n),
        .layout_q (layout_q),
        .code_in  (pipe_code),
        .dest_in  (pipe_dest),
        .vld_in   (pipe_vld),
        .port_a   (port_a),
        .port_b   (port_b),
        .pair_stb (pair_stb)
    );

    // Strobe: inverted clock in straight layout, registered pulse when paired.
    assign paired = (layout_q == LAYOUT_PAIRED);
    assign strobe = paired ? pair_stb : ~clk;
endmodule

// File: rtl/sample_demux_fmt_chk.sv
// Assertion checker bound to sample_demux_fmt.
// Does: checks layout stability, port ordering and strobe shape over time.
module sample_demux_fmt_chk #(
    parameter int CODE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              paired,
    input logic              pair_stb,
    input logic [CODE_W-1:0] port_a,
    input logic [CODE_W-1:0] port_b
);
    // Layout only changes through reset.
    p_layout_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> $stable(paired));

    // Straight: B takes the previous A whenever A changes.
    p_b_trails_a_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!paired && port_a != $past(port_a)) |-> port_b == $past(port_a));

    // Paired: the two ports never change on the same edge.
    p_one_port_r5: assert property (@(posedge clk) disable iff (!rst_n)
        paired |-> !(port_a != $past(port_a) && port_b != $past(port_b)));

    // Paired: strobe is never high on two consecutive cycles.
    p_stb_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (paired && pair_stb) |=> !pair_stb);

    // Strobe register is low on the cycle after reset.
    p_stb_rst_r8: assert property (@(posedge clk)
        !rst_n |=> !pair_stb);
endmodule

bind sample_demux_fmt sample_demux_fmt_chk #(.CODE_W(CODE_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .paired   (paired),
    .pair_stb (pair_stb),
    .port_a   (port_a),
    .port_b   (port_b)
);

// File: tb/sample_demux_fmt_tb.sv
// Directed bench for sample_demux_fmt: one task per scenario.
module sample_demux_fmt_tb;
    localparam int CLK_T = 10;
    localparam int LAT   = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rst2_n = 1'b0;
    logic [7:0] sample_in = '0;
    logic       paired_mode = 1'b0;
    logic       pol_true = 1'b1;
    logic [7:0] port_a, port_b, peer_a, peer_b;
    logic       strobe, peer_stb;
    int         checks = 0;
    int         fails = 0;

    always #(CLK_T/2) clk = ~clk;

    sample_demux_fmt #(.CODE_W(8), .LAT(LAT)) u_dut (
        .clk(clk), .rst_n(rst_n), .sample_in(sample_in),
        .paired_mode(paired_mode), .pol_true(pol_true),
        .port_a(port_a), .port_b(port_b), .strobe(strobe));

    sample_demux_fmt #(.CODE_W(8), .LAT(LAT)) u_peer (
        .clk(clk), .rst_n(rst2_n), .sample_in(sample_in),
        .paired_mode(paired_mode), .pol_true(pol_true),
        .port_a(peer_a), .port_b(peer_b), .strobe(peer_stb));

    // Compare one value and report.
    task automatic chk(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] fmt(input logic [7:0] v, input logic p);
        return p ? v : ~v;
    endfunction

    // Reset both instances; check the cleared state (R8).
    task automatic do_reset(input logic mode, input logic pol);
        @(negedge clk);
        rst_n = 1'b0; rst2_n = 1'b0;
        paired_mode = mode; pol_true = pol; sample_in = '0;
        repeat (2) @(negedge clk);
        chk("R8", "reset port_a", port_a, 8'h00);
        chk("R8", "reset port_b", port_b, 8'h00);
        if (mode) chk("R8", "reset strobe", {7'd0, strobe}, 8'h00);
        rst_n = 1'b1; rst2_n = 1'b1;
    endtask

    // Ramp in either layout; optional flip of the mode input after release (R1).
    task automatic run_ramp(input logic mode, input logic pol,
                            input logic [7:0] base, input int n, input logic flip);
        do_reset(mode, pol);
        for (int i = 0; i < n; i++) begin
            logic [7:0] ea, eb, es;
            int k;
            sample_in = base + 8'(i);
            if (flip && i == 3) paired_mode = ~mode;
            @(negedge clk);
            k = i - (LAT - 1);
            if (!mode) begin
                ea = (k >= 0) ? fmt(base + 8'(k), pol) : 8'h00;
                eb = (k >= 1) ? fmt(base + 8'(k - 1), pol) : 8'h00;
                chk(flip ? "R1" : "R2 R10", "straight port_a", port_a, ea);
                chk(flip ? "R1" : "R3", "straight port_b", port_b, eb);
                chk(flip ? "R1" : "R4", "straight strobe low phase", {7'd0, strobe}, 8'h01);
            end else begin
                if (k < 0) begin
                    ea = 8'h00; eb = 8'h00; es = 8'h00;
                end else if (k % 2 == 0) begin
                    ea = fmt(base + 8'(k), pol);
                    eb = (k >= 1) ? fmt(base + 8'(k - 1), pol) : 8'h00;
                    es = 8'h00;
                end else begin
                    ea = fmt(base + 8'(k - 1), pol);
                    eb = fmt(base + 8'(k), pol);
                    es = 8'h01;
                end
                chk(flip ? "R1" : "R5 R10", "paired port_a", port_a, ea);
                chk(flip ? "R1" : "R5", "paired port_b", port_b, eb);
                chk(flip ? "R1" : "R6", "paired strobe", {7'd0, strobe}, es);
            end
        end
        if (!mode) begin
            @(posedge clk);
            #(CLK_T/4);
            chk("R4", "straight strobe high phase", {7'd0, strobe}, 8'h00);
        end
    endtask

    // Polarity corner codes: top, mid, bottom (R7).
    task automatic pol_corners(input logic pol);
        logic [7:0] vals [3];
        vals[0] = 8'hFF; vals[1] = 8'h80; vals[2] = 8'h00;
        do_reset(1'b0, pol);
        for (int i = 0; i < 3 + LAT - 1; i++) begin
            int k;
            sample_in = (i < 3) ? vals[i] : 8'h55;
            @(negedge clk);
            k = i - (LAT - 1);
            if (k >= 0 && k < 3)
                chk("R7", "polarity corner", port_a, pol ? vals[k] : ~vals[k]);
        end
    endtask

    // Misaligned release, then common release of two instances (R9).
    task automatic align_test();
        logic diff_seen;
        @(negedge clk);
        rst_n = 1'b0; rst2_n = 1'b0; paired_mode = 1'b1; pol_true = 1'b1;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        rst2_n = 1'b1;
        diff_seen = 1'b0;
        for (int i = 0; i < 8; i++) begin
            sample_in = 8'h30 + 8'(i);
            @(negedge clk);
            if (strobe !== peer_stb) diff_seen = 1'b1;
        end
        chk("R9", "separate release shows phase lag", {7'd0, diff_seen}, 8'h01);
        do_reset(1'b1, 1'b1);
        for (int i = 0; i < 8; i++) begin
            sample_in = 8'hA0 + 8'(i);
            @(negedge clk);
            chk("R9", "aligned port_a", peer_a, port_a);
            chk("R9", "aligned port_b", peer_b, port_b);
            chk("R9", "aligned strobe", {7'd0, peer_stb}, {7'd0, strobe});
        end
    endtask

    initial begin
        #(CLK_T * 100000);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

    initial begin
        run_ramp(1'b0, 1'b1, 8'h10, 10, 1'b0);
        run_ramp(1'b0, 1'b0, 8'hFC, 10, 1'b0);
        run_ramp(1'b1, 1'b1, 8'h40, 12, 1'b0);
        run_ramp(1'b1, 1'b0, 8'h7D, 12, 1'b0);
        run_ramp(1'b0, 1'b1, 8'h20, 10, 1'b1);
        run_ramp(1'b1, 1'b1, 8'h60, 10, 1'b1);
        pol_corners(1'b1);
        pol_corners(1'b0);
        align_test();
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end
endmodule